// File: doc/BRIEF.md
# LIN-Ready Asynchronous Serial Transceiver

This block is a full-duplex 8N1 serial transceiver with extras for single-wire LIN-style buses. Bytes enter through a valid/ready transmit handshake. Received bytes are held in a one-byte buffer together with a framing-error bit, and stay there until the consumer pulses a read strobe. A divisor register sets the bit rate. The divisor is the number of system clocks per oversample tick, and sixteen ticks make one bit time.

Three bus features come on top of plain UART framing:

- **Break request.** It makes the transmitter send a 13-bit-time low break followed by a stop bit. The break goes out once the character already in flight has finished.
- **Auto-baud.** When armed, the receiver times the next incoming 0x55 sync character and writes the rounded divisor into the baud generator by itself.
- **Wake detector.** When armed, a falling edge on an idle line raises a wake flag instead of starting a character. The flag drops again when the line returns high.

A global enable gates the whole serial port. The block drives the direction of the transmit pin itself.

Top module: `lin_uart`

## Requirements
- R1: After reset the transmit line is high, tx_ready is high once port_en is set, rx_valid, wake_flag, autobaud_busy and break_pending are low, and divisor_out equals the DIV_RST parameter.
- R2: A transmitted byte appears on txd as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit after the start bit lasts exactly 16 × divisor clocks. The start bit lasts between 15 × divisor + 1 and 16 × divisor clocks.
- R3: The receiver samples each bit on oversample ticks 7, 8 and 9 and takes the majority vote. It places the byte on rx_data with rx_valid high. rx_valid stays high until rx_read is pulsed, and it falls on the clock edge that samples rx_read.
- R4: A received character whose stop bit votes low sets rx_frame_err, and the byte is still delivered. A good stop bit leaves rx_frame_err low.
- R5: rx_overrun is set when a byte completes while rx_valid is still high and unread. rx_data then holds the newer byte. rx_read clears both rx_valid and rx_overrun.
- R6: A one-cycle tx_break_req sets break_pending and holds tx_ready low. The character in progress finishes unchanged. After it, txd is low for 13 bit times (between 13 × 16 × divisor − divisor + 1 and 13 × 16 × divisor clocks), then high for one stop bit. break_pending falls at the end of that stop bit.
- R7: With wake_arm high and the receiver idle, a falling edge on rxd sets wake_flag on the third clock edge after the edge, counting the two synchronizer stages. The flag stays high while rxd is low. It clears on the third clock edge after rxd returns high. No byte is delivered for that low period.
- R8: A one-cycle autobaud_start raises autobaud_busy. The next 0x55 character on rxd is then timed from its first falling edge to its fifth falling edge (8 bit times, N clocks). divisor_out becomes (N + 64) / 128, clamped to at least 1. autobaud_busy falls, and no byte is delivered for that character.
- R9: While port_en is low, txd_oe is low, tx_ready is low, txd is high, and activity on rxd delivers no byte.
- R10: A divisor_wr pulse loads divisor_in into the baud generator; divisor_out shows it one clock edge later. A written value of 0 is stored as 1.
- R11: The transmitter and receiver run at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Global serial port enable |
| divisor_in | input | DIV_W | Divisor value to load |
| divisor_wr | input | 1 | Load strobe for divisor_in |
| divisor_out | output | DIV_W | Current clocks-per-tick divisor |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| tx_break_req | input | 1 | Request one break character |
| break_pending | output | 1 | Break requested or in progress |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Output enable for the transmit pin |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_frame_err | output | 1 | Stop bit of rx_data was low |
| rx_overrun | output | 1 | A byte arrived while the previous one was unread |
| rx_read | input | 1 | Consume the buffered byte |
| wake_arm | input | 1 | Enable the break wake detector |
| wake_flag | output | 1 | Wake break in progress on rxd |
| autobaud_start | input | 1 | Arm one auto-baud measurement |
| autobaud_busy | output | 1 | Auto-baud armed or measuring |

## Verification
Each result has its own due time:

- **Divisor load.** It is visible on the first clock edge after the load strobe.
- **Wake flag.** It rises exactly on the third clock edge after rxd falls, and falls on the third edge after rxd rises. The bench checks one cycle early that the flag has not yet moved, then checks it on the due cycle.
- **Serial bits.** Their timing is anchored to the observed falling edge of txd, because the first bit may be shortened by up to one tick. The bench samples each bit in the middle of its window, and counts the break's low time against a one-tick tolerance.
- **Received bytes.** The bench checks each one after the stop bit has been sampled, polling for a bounded window.
- **Auto-baud results.** The bench checks them only after the whole sync character has ended.

// File: rtl/lin_uart_pkg.sv
package lin_uart_pkg;

    // oversample factor and derived counter width
    localparam int OSR      = 16;
    localparam int OSR_W    = $clog2(OSR);
    // length of a transmitted break, in bit times, start bit included
    localparam int BRK_BITS = 13;
    localparam int BRK_W    = $clog2(BRK_BITS);
    // auto-baud: sync span is 8 bit times of OSR ticks each
    localparam int AB_SPAN  = 8;
    localparam int AB_SH    = $clog2(AB_SPAN * OSR);
    localparam int AB_EDGES = 5;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP,
        TX_BRK
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAKE,
        RX_AB_CNT,
        RX_AB_END
    } rx_state_e;

endpackage

// File: rtl/lin_uart_brg.sv
module lin_uart_brg #(
    parameter int DIV_W   = 12,
    parameter int DIV_RST = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic [DIV_W-1:0] div_o,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } brg_s;

    brg_s q, d;
    logic tick;

    // one tick every div clocks
    assign tick = (q.cnt == q.div - 1'b1);

    always_comb begin
        d     = q;
        d.cnt = tick ? '0 : q.cnt + 1'b1;
        if (load) begin
            d.div = (load_val == '0) ? DIV_W'(1) : load_val;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.div <= DIV_W'(DIV_RST);
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign div_o  = q.div;
    assign tick_o = tick;

endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx
    import lin_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic [7:0] data,
    input  logic       valid,
    output logic       ready,
    input  logic       brk_req,
    output logic       brk_pend,
    output logic       txd
);

    typedef struct packed {
        tx_state_e        st;
        logic [7:0]       sh;
        logic [OSR_W-1:0] tc;
        logic [BRK_W-1:0] bc;
        logic             brk;
        logic             in_brk;
    } tx_s;

    tx_s  q, d;
    logic bit_end;

    assign bit_end = tick && (q.tc == OSR_W'(OSR - 1));

    always_comb begin
        d = q;
        if (brk_req) d.brk = 1'b1;
        if (tick)    d.tc  = bit_end ? '0 : q.tc + 1'b1;

        if (!en) begin
            d.st     = TX_IDLE;
            d.brk    = 1'b0;
            d.in_brk = 1'b0;
            d.tc     = '0;
            d.bc     = '0;
        end else begin
            unique case (q.st)
                TX_IDLE: begin
                    d.tc = '0;
                    d.bc = '0;
                    if (q.brk) begin
                        d.st     = TX_BRK;
                        d.in_brk = 1'b1;
                    end else if (valid) begin
                        d.st = TX_START;
                        d.sh = data;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        d.st = TX_DATA;
                        d.bc = '0;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        d.sh = q.sh >> 1;
                        if (q.bc == BRK_W'(7)) d.st = TX_STOP;
                        else                   d.bc = q.bc + 1'b1;
                    end
                end
                TX_BRK: begin
                    if (bit_end) begin
                        if (q.bc == BRK_W'(BRK_BITS - 1)) d.st = TX_STOP;
                        else                              d.bc = q.bc + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        d.st = TX_IDLE;
                        if (q.in_brk) begin
                            d.brk    = brk_req;
                            d.in_brk = 1'b0;
                        end
                    end
                end
                default: d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= TX_IDLE;
            q.sh     <= '0;
            q.tc     <= '0;
            q.bc     <= '0;
            q.brk    <= 1'b0;
            q.in_brk <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            TX_START, TX_BRK: txd = 1'b0;
            TX_DATA:          txd = q.sh[0];
            default:          txd = 1'b1;
        endcase
    end

    assign ready    = en && (q.st == TX_IDLE) && !q.brk;
    assign brk_pend = q.brk;

endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx
    import lin_uart_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             rxd,
    input  logic             rd,
    input  logic             wake_arm,
    input  logic             ab_start,
    output logic [7:0]       data_o,
    output logic             valid_o,
    output logic             ferr_o,
    output logic             ovr_o,
    output logic             wake_o,
    output logic             ab_busy_o,
    output logic             ab_wr_o,
    output logic [DIV_W-1:0] ab_div_o
);

    localparam int CNT_W   = DIV_W + AB_SH + 1;
    localparam int MID     = OSR / 2;
    localparam int AB_HALF = 1 << (AB_SH - 1);
    localparam int DIV_MAX = (1 << DIV_W) - 1;

    typedef struct packed {
        rx_state_e        st;
        logic             s1;
        logic             s2;
        logic             s3;
        logic [OSR_W-1:0] tc;
        logic [2:0]       bc;
        logic [1:0]       votes;
        logic [7:0]       sh;
        logic [7:0]       data;
        logic             valid;
        logic             ferr;
        logic             ovr;
        logic             wake;
        logic             ab_arm;
        logic             ab_wr;
        logic [2:0]       edges;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] ab_div;
    } rx_s;

    rx_s              q, d;
    logic             line, fall, bit_end, win;
    logic [1:0]       v_now;
    logic [CNT_W-1:0] rnd, quo;
    logic [DIV_W-1:0] ab_calc;

    assign line    = q.s2;
    assign fall    = q.s3 & ~q.s2;
    assign bit_end = tick && (q.tc == OSR_W'(OSR - 1));
    assign win     = tick && (q.tc >= OSR_W'(MID - 1)) && (q.tc <= OSR_W'(MID + 1));
    assign v_now   = q.votes + {1'b0, line};
    assign rnd     = q.cnt + CNT_W'(AB_HALF);
    assign quo     = rnd >> AB_SH;
    assign ab_calc = (quo == '0)                ? DIV_W'(1) :
                     (quo > CNT_W'(DIV_MAX))    ? DIV_W'(DIV_MAX) :
                                                  quo[DIV_W-1:0];

    always_comb begin
        d       = q;
        d.s1    = rxd;
        d.s2    = q.s1;
        d.s3    = q.s2;
        d.ab_wr = 1'b0;
        if (ab_start) d.ab_arm = 1'b1;
        if (rd) begin
            d.valid = 1'b0;
            d.ovr   = 1'b0;
        end
        if (tick) d.tc = bit_end ? '0 : q.tc + 1'b1;
        if (win)  d.votes = v_now;

        if (!en) begin
            d.st   = RX_IDLE;
            d.wake = 1'b0;
            d.tc   = '0;
        end else begin
            unique case (q.st)
                RX_IDLE: begin
                    d.tc    = '0;
                    d.votes = '0;
                    d.bc    = '0;
                    if (fall) begin
                        if (q.ab_arm) begin
                            d.st    = RX_AB_CNT;
                            d.cnt   = CNT_W'(1);
                            d.edges = 3'd1;
                        end else if (wake_arm) begin
                            d.st   = RX_WAKE;
                            d.wake = 1'b1;
                        end else begin
                            d.st = RX_START;
                        end
                    end
                end
                RX_START: begin
                    if (bit_end) begin
                        d.votes = '0;
                        d.st    = q.votes[1] ? RX_IDLE : RX_DATA;
                        d.bc    = '0;
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        d.votes = '0;
                        d.sh    = {q.votes[1], q.sh[7:1]};
                        if (q.bc == 3'd7) d.st = RX_STOP;
                        else              d.bc = q.bc + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick && q.tc == OSR_W'(MID + 1)) begin
                        d.st    = RX_IDLE;
                        d.data  = q.sh;
                        d.ferr  = ~v_now[1];
                        d.valid = 1'b1;
                        if (q.valid && !rd) d.ovr = 1'b1;
                    end
                end
                RX_WAKE: begin
                    if (line) begin
                        d.wake = 1'b0;
                        d.st   = RX_IDLE;
                    end
                end
                RX_AB_CNT: begin
                    if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
                    if (fall) begin
                        d.edges = q.edges + 1'b1;
                        if (q.edges == 3'(AB_EDGES - 1)) begin
                            d.st     = RX_AB_END;
                            d.ab_arm = 1'b0;
                            d.ab_wr  = 1'b1;
                            d.ab_div = ab_calc;
                        end
                    end
                end
                RX_AB_END: begin
                    if (line) d.st = RX_IDLE;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= RX_IDLE;
            q.s1     <= 1'b1;
            q.s2     <= 1'b1;
            q.s3     <= 1'b1;
            q.tc     <= '0;
            q.bc     <= '0;
            q.votes  <= '0;
            q.sh     <= '0;
            q.data   <= '0;
            q.valid  <= 1'b0;
            q.ferr   <= 1'b0;
            q.ovr    <= 1'b0;
            q.wake   <= 1'b0;
            q.ab_arm <= 1'b0;
            q.ab_wr  <= 1'b0;
            q.edges  <= '0;
            q.cnt    <= '0;
            q.ab_div <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_o    = q.data;
    assign valid_o   = q.valid;
    assign ferr_o    = q.ferr;
    assign ovr_o     = q.ovr;
    assign wake_o    = q.wake;
    assign ab_busy_o = q.ab_arm;
    assign ab_wr_o   = q.ab_wr;
    assign ab_div_o  = q.ab_div;

endmodule

// File: rtl/lin_uart.sv
module lin_uart #(
    parameter int DIV_W   = 12,
    parameter int DIV_RST = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_en,
    input  logic [DIV_W-1:0] divisor_in,
    input  logic             divisor_wr,
    output logic [DIV_W-1:0] divisor_out,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic             tx_break_req,
    output logic             break_pending,
    output logic             txd,
    output logic             txd_oe,
    input  logic             rxd,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_frame_err,
    output logic             rx_overrun,
    input  logic             rx_read,
    input  logic             wake_arm,
    output logic             wake_flag,
    input  logic             autobaud_start,
    output logic             autobaud_busy
);

    logic             tick;
    logic             ab_wr;
    logic [DIV_W-1:0] ab_div;
    logic             brg_load;
    logic [DIV_W-1:0] brg_val;

    // a measured divisor takes priority over a software write in the same cycle
    assign brg_load = divisor_wr | ab_wr;
    assign brg_val  = ab_wr ? ab_div : divisor_in;

    lin_uart_brg #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) brg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (brg_load),
        .load_val (brg_val),
        .div_o    (divisor_out),
        .tick_o   (tick)
    );

    lin_uart_tx tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (port_en),
        .tick     (tick),
        .data     (tx_data),
        .valid    (tx_valid),
        .ready    (tx_ready),
        .brk_req  (tx_break_req),
        .brk_pend (break_pending),
        .txd      (txd)
    );

    lin_uart_rx #(
        .DIV_W (DIV_W)
    ) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (port_en),
        .tick      (tick),
        .rxd       (rxd),
        .rd        (rx_read),
        .wake_arm  (wake_arm),
        .ab_start  (autobaud_start),
        .data_o    (rx_data),
        .valid_o   (rx_valid),
        .ferr_o    (rx_frame_err),
        .ovr_o     (rx_overrun),
        .wake_o    (wake_flag),
        .ab_busy_o (autobaud_busy),
        .ab_wr_o   (ab_wr),
        .ab_div_o  (ab_div)
    );

    assign txd_oe = port_en;

endmodule

// File: rtl/lin_uart_chk.sv
module lin_uart_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en,
    input logic [DIV_W-1:0] divisor_out,
    input logic             tx_ready,
    input logic             break_pending,
    input logic             txd,
    input logic             txd_oe,
    input logic             rx_valid,
    input logic             rx_overrun,
    input logic             wake_arm,
    input logic             wake_flag
);

    // R9
    port_off_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (!txd_oe && !tx_ready));

    // R9
    port_off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && !$past(port_en)) |-> txd);

    // R2
    ready_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R6
    break_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        break_pending |-> !tx_ready);

    // R6
    break_ends_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(break_pending) |-> txd);

    // R7
    wake_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(wake_arm));

    // R7
    wake_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_flag |-> !$rose(rx_valid));

    // R5
    overrun_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_valid);

    // R10
    divisor_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        divisor_out != '0);

endmodule

bind lin_uart lin_uart_chk #(.DIV_W(DIV_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_en       (port_en),
    .divisor_out   (divisor_out),
    .tx_ready      (tx_ready),
    .break_pending (break_pending),
    .txd           (txd),
    .txd_oe        (txd_oe),
    .rx_valid      (rx_valid),
    .rx_overrun    (rx_overrun),
    .wake_arm      (wake_arm),
    .wake_flag     (wake_flag)
);

// File: tb/lin_uart_tb_top.sv
module lin_uart_tb_top;

    localparam int DIV_W   = 12;
    localparam int DIV_RST = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             port_en = 1'b0;
    logic [DIV_W-1:0] divisor_in = '0;
    logic             divisor_wr = 1'b0;
    logic [DIV_W-1:0] divisor_out;
    logic [7:0]       tx_data = '0;
    logic             tx_valid = 1'b0;
    logic             tx_ready;
    logic             tx_break_req = 1'b0;
    logic             break_pending;
    logic             txd;
    logic             txd_oe;
    logic             rxd;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             rx_frame_err;
    logic             rx_overrun;
    logic             rx_read = 1'b0;
    logic             wake_arm = 1'b0;
    logic             wake_flag;
    logic             autobaud_start = 1'b0;
    logic             autobaud_busy;
    logic             lb = 1'b0;
    logic             rx_drv = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    assign rxd = lb ? txd : rx_drv;

    always #10 clk = ~clk;

    lin_uart #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .port_en        (port_en),
        .divisor_in     (divisor_in),
        .divisor_wr     (divisor_wr),
        .divisor_out    (divisor_out),
        .tx_data        (tx_data),
        .tx_valid       (tx_valid),
        .tx_ready       (tx_ready),
        .tx_break_req   (tx_break_req),
        .break_pending  (break_pending),
        .txd            (txd),
        .txd_oe         (txd_oe),
        .rxd            (rxd),
        .rx_data        (rx_data),
        .rx_valid       (rx_valid),
        .rx_frame_err   (rx_frame_err),
        .rx_overrun     (rx_overrun),
        .rx_read        (rx_read),
        .wake_arm       (wake_arm),
        .wake_flag      (wake_flag),
        .autobaud_start (autobaud_start),
        .autobaud_busy  (autobaud_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, 190000);
            report();
            $finish;
        end
    end

    task automatic set_div(input int v);
        @(negedge clk);
        divisor_in = DIV_W'(v);
        divisor_wr = 1'b1;
        @(negedge clk);
        divisor_wr = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // samples a whole frame mid-bit, anchored on the observed start edge
    task automatic cap_tx(input int dv, output logic [9:0] f);
        while (txd) @(negedge clk);
        repeat (8 * dv) @(negedge clk);
        f[0] = txd;
        for (int k = 1; k < 10; k++) begin
            repeat (16 * dv) @(negedge clk);
            f[k] = txd;
        end
    endtask

    task automatic drive_rx(input logic [7:0] b, input logic stopv, input int bt);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (bt) @(negedge clk);
        end
        rx_drv = stopv;
        repeat (bt) @(negedge clk);
        rx_drv = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    task automatic wait_rx(input int lim, output bit got);
        got = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (rx_valid) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic do_read();
        @(negedge clk);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic loop_byte(input logic [7:0] b, input int dv, input string req);
        logic [9:0] f;
        bit got;
        fork
            send_tx(b);
            cap_tx(dv, f);
        join
        chk(f == {1'b1, b, 1'b0}, "R2 tx frame", int'(f), int'({1'b1, b, 1'b0}));
        wait_rx(40 * dv, got);
        chk(got && rx_data == b && !rx_frame_err, req, int'(rx_data), int'(b));
        do_read();
    endtask

    initial begin
        logic [9:0] f;
        bit got;
        int n;
        int lowc;

        repeat (5) @(negedge clk);
        rst_n   = 1'b1;
        port_en = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        chk(wake_flag == 1'b0 && autobaud_busy == 1'b0 && break_pending == 1'b0,
            "R1 flags", int'({wake_flag, autobaud_busy, break_pending}), 0);
        chk(divisor_out == DIV_W'(DIV_RST), "R1 divisor", int'(divisor_out), DIV_RST);
        chk(txd_oe == 1'b1, "R9 txd_oe enabled", int'(txd_oe), 1);

        // R10 divisor load, zero stored as one
        set_div(0);
        chk(divisor_out == DIV_W'(1), "R10 zero write", int'(divisor_out), 1);
        set_div(2);
        chk(divisor_out == DIV_W'(2), "R10 write", int'(divisor_out), 2);

        // R2 / R3: every byte in loopback at divisor 1
        set_div(1);
        lb = 1'b1;
        for (int b = 0; b < 256; b++) loop_byte(8'(b), 1, "R3 loopback div1");
        // a sample at divisor 3
        set_div(3);
        for (int i = 0; i < 16; i++) loop_byte(8'((i * 37) ^ 8'h5A), 3, "R3 loopback div3");

        // R4 framing error and good stop
        lb = 1'b0;
        set_div(2);
        drive_rx(8'hC3, 1'b0, 32);
        chk(rx_valid && rx_frame_err, "R4 stop low flags error", int'({rx_valid, rx_frame_err}), 3);
        chk(rx_data == 8'hC3, "R4 byte still delivered", int'(rx_data), 8'hC3);
        do_read();
        chk(!rx_valid, "R3 read clears valid", int'(rx_valid), 0);
        drive_rx(8'h18, 1'b1, 32);
        chk(rx_valid && !rx_frame_err && rx_data == 8'h18, "R4 good stop", int'(rx_data), 8'h18);
        do_read();

        // R5 overrun
        drive_rx(8'h3C, 1'b1, 32);
        drive_rx(8'hA5, 1'b1, 32);
        chk(rx_overrun && rx_valid, "R5 overrun set", int'({rx_overrun, rx_valid}), 3);
        chk(rx_data == 8'hA5, "R5 newer byte", int'(rx_data), 8'hA5);
        do_read();
        chk(!rx_overrun && !rx_valid, "R5 read clears", int'({rx_overrun, rx_valid}), 0);

        // R9 port disabled
        port_en = 1'b0;
        @(negedge clk);
        chk(!txd_oe && !tx_ready, "R9 pins off", int'({txd_oe, tx_ready}), 0);
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        lowc = 0;
        fork
            drive_rx(8'h66, 1'b1, 32);
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (!txd) lowc++;
            end
        join
        tx_valid = 1'b0;
        chk(lowc == 0, "R9 txd held high", lowc, 0);
        chk(!rx_valid, "R9 no byte received", int'(rx_valid), 0);
        port_en = 1'b1;
        @(negedge clk);

        // R6 break after the character in flight
        fork
            begin
                send_tx(8'h0F);
                repeat (20) @(negedge clk);
                tx_break_req = 1'b1;
                @(negedge clk);
                tx_break_req = 1'b0;
                chk(break_pending && !tx_ready, "R6 pending blocks ready",
                    int'({break_pending, tx_ready}), 2);
            end
            cap_tx(2, f);
        join
        chk(f == {1'b1, 8'h0F, 1'b0}, "R6 current char unchanged", int'(f), int'({1'b1, 8'h0F, 1'b0}));
        while (txd) @(negedge clk);
        n = 0;
        while (!txd) begin
            n++;
            @(negedge clk);
        end
        chk(n >= 13 * 32 - 1 && n <= 13 * 32, "R6 break low length", n, 13 * 32);
        repeat (16) @(negedge clk);
        chk(break_pending && txd, "R6 pending through stop", int'({break_pending, txd}), 3);
        repeat (32) @(negedge clk);
        chk(!break_pending && tx_ready, "R6 pending cleared", int'({break_pending, tx_ready}), 1);

        // R7 wake detector
        wake_arm = 1'b1;
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (2) @(negedge clk);
        chk(!wake_flag, "R7 flag not yet", int'(wake_flag), 0);
        @(negedge clk);
        chk(wake_flag, "R7 flag on third edge", int'(wake_flag), 1);
        repeat (2000) @(negedge clk);
        chk(wake_flag && !rx_valid, "R7 held during break", int'({wake_flag, rx_valid}), 2);
        rx_drv = 1'b1;
        repeat (2) @(negedge clk);
        chk(wake_flag, "R7 still high", int'(wake_flag), 1);
        @(negedge clk);
        chk(!wake_flag, "R7 self clear", int'(wake_flag), 0);
        repeat (300) @(negedge clk);
        chk(!rx_valid, "R7 no byte for break", int'(rx_valid), 0);
        wake_arm = 1'b0;

        // R8 auto-baud
        set_div(9);
        @(negedge clk);
        autobaud_start = 1'b1;
        @(negedge clk);
        autobaud_start = 1'b0;
        chk(autobaud_busy, "R8 busy armed", int'(autobaud_busy), 1);
        drive_rx(8'h55, 1'b1, 80);
        chk(!autobaud_busy && divisor_out == DIV_W'(5), "R8 measured 80", int'(divisor_out), 5);
        chk(!rx_valid, "R8 sync not delivered", int'(rx_valid), 0);
        @(negedge clk);
        autobaud_start = 1'b1;
        @(negedge clk);
        autobaud_start = 1'b0;
        drive_rx(8'h55, 1'b1, 48);
        chk(!autobaud_busy && divisor_out == DIV_W'(3), "R8 measured 48", int'(divisor_out), 3);
        lb = 1'b1;
        loop_byte(8'hB7, 3, "R8 new rate works");
        lb = 1'b0;

        // R11 simultaneous transmit and receive
        set_div(2);
        fork
            send_tx(8'h9E);
            cap_tx(2, f);
            drive_rx(8'h21, 1'b1, 32);
        join
        chk(f == {1'b1, 8'h9E, 1'b0}, "R11 tx during rx", int'(f), int'({1'b1, 8'h9E, 1'b0}));
        chk(rx_valid && rx_data == 8'h21, "R11 rx during tx", int'(rx_data), 8'h21);
        do_read();

        report();
        $finish;
    end

endmodule